// File: doc/BRIEF.md
# Descriptor DMA Channel Status Controller

This block holds the status and sequencing state of one descriptor-driven DMA channel. The datapath reports events to it: a descriptor was fetched, with or without its valid flag; a descriptor or buffer pointer was bad; the 16-bit length count reached zero, with or without the descriptor's last flag; or the peripheral ended the transfer early with a done strobe. A firmware abort request level is also an input. From these events the block sets sticky pending bits, which firmware clears by writing one. It holds the channel stopped while an error, not-ready or abort cause is pending.

When firmware clears a halting cause, the block tells the datapath what to do next. After an error it retries the same descriptor from where it stopped. After an abort it moves on to the next descriptor. After a not-ready descriptor it simply resumes without a move. A single register word holds the pending bits at the top and the matching interrupt enables at the bottom. The interrupt output combines the two.

Top module: `dma_chan_status`

## Requirements
- R1: After reset, and at any time, the register reads with pending bits at fixed positions: 31 normal done, 30 error, 29 not ready, 28 abort, 27 premature done. The enables sit at bits 4 (normal), 3 (error), 2 (not ready), 1 (abort) and 0 (premature). Every other bit, including the reserved bits 26:25, reads 0. After reset every bit reads 0.
- R2: A register write clears each pending bit whose data bit is 1 and leaves the pending bits whose data bit is 0 unchanged. The same write loads bits 4:0 into the enables.
- R3: Length-zero with the last flag set sets normal done and pulses desc_advance. Length-zero without the last flag pulses desc_advance and sets no pending bit.
- R4: A done strobe sets both normal done and premature done, and pulses desc_advance.
- R5: A bad pointer sets error and halts the channel with no advance. Clearing error pulses desc_retry and does not pulse desc_advance.
- R6: A fetch whose valid flag is clear sets not ready and halts the channel. Clearing not ready resumes the channel with neither desc_advance nor desc_retry.
- R7: While the channel runs, an abort request sets abort and halts the channel. Clearing abort pulses desc_advance. If the request is still high at that point, abort is set again on the next cycle.
- R8: irq is high exactly when some pending bit and its enable are both 1.
- R9: When a hardware set and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R10: chan_run is low while error, not ready or abort is pending. Datapath events that arrive while the channel is halted set nothing and pulse nothing.
- R11: When several events arrive in one cycle, only the highest-priority one acts. The order is abort, then bad pointer, then invalid fetch, then done strobe, then length-zero.
- R12: desc_advance and desc_retry are single-cycle pulses. Each appears in the cycle after the clock edge that sampled its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Write data: bits 31:27 clear pending bits, bits 4:0 load the enables |
| reg_rd_data | output | 32 | Register read value |
| abort_req | input | 1 | Firmware abort request level |
| fetch_vld | input | 1 | Descriptor fetch completed this cycle |
| fetch_full | input | 1 | Valid flag of the fetched descriptor |
| bad_ptr | input | 1 | Bad descriptor or buffer pointer seen |
| len_zero | input | 1 | Length count reached zero |
| last_flag | input | 1 | Last flag of the current descriptor |
| done_strobe | input | 1 | Peripheral ended the transfer early |
| chan_run | output | 1 | Channel may run |
| desc_advance | output | 1 | Pulse: move to the next descriptor |
| desc_retry | output | 1 | Pulse: restart the current descriptor |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions expect the datapath to raise its event inputs only while chan_run is high. They also expect at most one halting cause to be pending at a time. The block's priority decoder guarantees the second point. The stimulus gives each event from a clean, running state and clears all pending bits before the next vector. It breaks the first expectation only on purpose, in the one directed case that shows events are ignored while the channel is halted.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
    localparam int PEND_N = 5;
    // index of each cause inside the pending and enable vectors
    localparam int IDX_NC = 4;
    localparam int IDX_EC = 3;
    localparam int IDX_NR = 2;
    localparam int IDX_CA = 1;
    localparam int IDX_PC = 0;
    localparam logic [PEND_N-1:0] HALT_MASK =
        (PEND_N'(1) << IDX_EC) | (PEND_N'(1) << IDX_NR) | (PEND_N'(1) << IDX_CA);

    typedef struct packed {
        logic [PEND_N-1:0] pend;
        logic [PEND_N-1:0] en;
        logic              adv;
        logic              retry;
    } stat_reg_t;
endpackage

// File: rtl/dma_stat_evt_dec.sv
module dma_stat_evt_dec
    import dma_stat_pkg::*;
(
    input  logic              run,
    input  logic              abort_req,
    input  logic              bad_ptr,
    input  logic              fetch_vld,
    input  logic              fetch_full,
    input  logic              len_zero,
    input  logic              last_flag,
    input  logic              done_strobe,
    output logic [PEND_N-1:0] set_vec,
    output logic              adv_evt
);
    // Priority: abort, bad pointer, invalid fetch, done strobe, length zero.
    always_comb begin
        set_vec = '0;
        adv_evt = 1'b0;
        if (run) begin
            if (abort_req) begin
                set_vec[IDX_CA] = 1'b1;
            end else if (bad_ptr) begin
                set_vec[IDX_EC] = 1'b1;
            end else if (fetch_vld && !fetch_full) begin
                set_vec[IDX_NR] = 1'b1;
            end else if (done_strobe) begin
                set_vec[IDX_NC] = 1'b1;
                set_vec[IDX_PC] = 1'b1;
                adv_evt         = 1'b1;
            end else if (len_zero) begin
                set_vec[IDX_NC] = last_flag;
                adv_evt         = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_stat_pend_bit.sv
module dma_stat_pend_bit (
    input  logic cur,
    input  logic set,
    input  logic clr,
    output logic nxt
);
    // a set in the same cycle as a clear keeps the bit
    always_comb begin
        nxt = set | (cur & ~clr);
    end
endmodule

// File: rtl/dma_stat_rdmux.sv
module dma_stat_rdmux
    import dma_stat_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PEND_LSB = 27,
    parameter int EN_LSB   = 0
) (
    input  logic [PEND_N-1:0] pend,
    input  logic [PEND_N-1:0] en,
    output logic [DATA_W-1:0] rd
);
    always_comb begin
        rd                       = '0;
        rd[PEND_LSB +: PEND_N]   = pend;
        rd[EN_LSB +: PEND_N]     = en;
    end
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
    import dma_stat_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PEND_TOP = 31,
    parameter int EN_LSB   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              abort_req,
    input  logic              fetch_vld,
    input  logic              fetch_full,
    input  logic              bad_ptr,
    input  logic              len_zero,
    input  logic              last_flag,
    input  logic              done_strobe,
    output logic              chan_run,
    output logic              desc_advance,
    output logic              desc_retry,
    output logic              irq
);
    localparam int PEND_LSB = PEND_TOP - PEND_N + 1;

    stat_reg_t         st_d, st_q;
    logic [PEND_N-1:0] set_vec;
    logic [PEND_N-1:0] clr_vec;
    logic [PEND_N-1:0] pend_nxt;
    logic              adv_evt;
    logic              run;

    assign run     = ~|(st_q.pend & HALT_MASK);
    assign clr_vec = reg_wr_en ? reg_wr_data[PEND_LSB +: PEND_N] : '0;

    dma_stat_evt_dec u_dec (
        .run         (run),
        .abort_req   (abort_req),
        .bad_ptr     (bad_ptr),
        .fetch_vld   (fetch_vld),
        .fetch_full  (fetch_full),
        .len_zero    (len_zero),
        .last_flag   (last_flag),
        .done_strobe (done_strobe),
        .set_vec     (set_vec),
        .adv_evt     (adv_evt)
    );

    for (genvar i = 0; i < PEND_N; i++) begin : g_pend
        dma_stat_pend_bit u_bit (
            .cur (st_q.pend[i]),
            .set (set_vec[i]),
            .clr (clr_vec[i]),
            .nxt (pend_nxt[i])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.pend  = pend_nxt;
        if (reg_wr_en) begin
            st_d.en = reg_wr_data[EN_LSB +: PEND_N];
        end
        // resume actions: abort moves on, error restarts, not-ready does neither
        st_d.adv   = adv_evt | (st_q.pend[IDX_CA] & clr_vec[IDX_CA]);
        st_d.retry = st_q.pend[IDX_EC] & clr_vec[IDX_EC];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dma_stat_rdmux #(
        .DATA_W   (DATA_W),
        .PEND_LSB (PEND_LSB),
        .EN_LSB   (EN_LSB)
    ) u_rd (
        .pend (st_q.pend),
        .en   (st_q.en),
        .rd   (reg_rd_data)
    );

    assign chan_run     = run;
    assign desc_advance = st_q.adv;
    assign desc_retry   = st_q.retry;
    assign irq          = |(st_q.pend & st_q.en);
endmodule

// File: rtl/dma_chan_status_chk.sv
module dma_chan_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rd_data,
    input logic        chan_run,
    input logic        desc_advance,
    input logic        desc_retry,
    input logic        irq
);
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[26:5] == '0); // R1
    AST_PREMATURE_SETS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rd_data[27]) |-> reg_rd_data[31]); // R4
    AST_ERROR_CLEAR_RETRIES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rd_data[30]) |-> (desc_retry && !desc_advance)); // R5
    AST_NOTREADY_CLEAR_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rd_data[29]) |-> (!desc_retry && !desc_advance)); // R6
    AST_ABORT_CLEAR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rd_data[28]) |-> desc_advance); // R7
    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(reg_rd_data[31:27] & reg_rd_data[4:0])); // R8
    AST_HALT_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_rd_data[30:28]) |-> !chan_run); // R10
    AST_ONE_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_rd_data[30:28])); // R11
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_advance && desc_retry)); // R12
endmodule

bind dma_chan_status dma_chan_status_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_rd_data  (reg_rd_data),
    .chan_run     (chan_run),
    .desc_advance (desc_advance),
    .desc_retry   (desc_retry),
    .irq          (irq)
);

// File: tb/sim_dma_chan_status.sv
`timescale 1ns/1ps
module sim_dma_chan_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        abort_req = 1'b0, fetch_vld = 1'b0, fetch_full = 1'b0, bad_ptr = 1'b0;
    logic        len_zero = 1'b0, last_flag = 1'b0, done_strobe = 1'b0;
    logic        chan_run, desc_advance, desc_retry, irq;
    int          checks = 0;
    int          failures = 0;

    always #4 clk = ~clk;

    dma_chan_status u0 (.*);

    // {abort,bad,fetch,full,lz,last,done} {pend[31:27]} adv retry run
    localparam logic [14:0] VEC [12] = '{
        15'b0000110_10000_101, // R3 length zero with last
        15'b0000100_00000_101, // R3 length zero, not last
        15'b0000001_10001_101, // R4 done strobe
        15'b0011000_00000_001, // R6 valid fetch
        15'b0010000_00100_000, // R6 invalid fetch
        15'b0100000_01000_000, // R5 bad pointer
        15'b1000000_00010_000, // R7 abort
        15'b1100000_00010_000, // R11 abort over bad
        15'b0110000_01000_000, // R11 bad over invalid
        15'b0010001_00100_000, // R11 invalid over done
        15'b0000111_10001_101, // R11 done over length zero
        15'b0000000_00000_001  // idle
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_wr_data = d;
        step();
        reg_wr_en = 1'b0;
        reg_wr_data = '0;
    endtask

    task automatic set_ev(input logic [6:0] e);
        {abort_req, bad_ptr, fetch_vld, fetch_full, len_zero, last_flag, done_strobe} = e;
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset reg", reg_rd_data, 32'h0);
        check("R1 reset outs", {31'b0, chan_run, desc_advance, desc_retry, irq}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2: reserved and unused bits read 0, enables load
        wr(32'h07FF_FFFF);
        check("R1 R2 readback", reg_rd_data, 32'h0000_001F);

        for (int i = 0; i < 12; i++) begin
            set_ev(VEC[i][14:8]);
            step();
            set_ev('0);
            check("R3 R4 R5 R6 R7 R11 pend", {27'b0, reg_rd_data[31:27]}, {27'b0, VEC[i][7:3]});
            check("R12 R10 pulses/run", {29'b0, desc_advance, desc_retry, chan_run},
                  {29'b0, VEC[i][2:0]});
            check("R8 irq table", {31'b0, irq}, {31'b0, |VEC[i][7:3]});
            wr(32'hF800_001F);
            step();
        end

        // R12: advance pulse lasts one cycle
        set_ev(7'b0000110);
        step();
        set_ev('0);
        step();
        check("R12 pulse width", {31'b0, desc_advance}, 32'h0);
        // R2: writing 0 to pending leaves it
        wr(32'h0000_001F);
        check("R2 zero write keeps", reg_rd_data, 32'h8000_001F);
        wr(32'h8000_0000);
        check("R2 clear and enables", reg_rd_data, 32'h0);

        // R8: enable gating
        set_ev(7'b0000110);
        step();
        set_ev('0);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(32'h0000_0010);
        check("R8 irq enabled", {31'b0, irq}, 32'h1);
        wr(32'hF800_001F);

        // R9: set wins over simultaneous clear
        set_ev(7'b0000001);
        wr(32'hF800_001F);
        set_ev('0);
        check("R9 set wins", {27'b0, reg_rd_data[31:27]}, 32'h11);
        wr(32'hF800_001F);

        // R5 resume: retry, no advance
        set_ev(7'b0100000);
        step();
        set_ev('0);
        wr(32'h4000_001F);
        check("R5 retry", {29'b0, desc_advance, desc_retry, chan_run}, 32'h3);
        step();
        check("R12 retry one cycle", {31'b0, desc_retry}, 32'h0);

        // R10: events ignored while halted
        set_ev(7'b0010000);
        step();
        set_ev(7'b0000111);
        step();
        set_ev('0);
        check("R10 halted ignore", {27'b0, reg_rd_data[31:27]}, 32'h04);
        check("R10 no pulse", {30'b0, desc_advance, chan_run}, 32'h0);
        // R6 resume: neither pulse
        wr(32'h2000_001F);
        check("R6 resume", {29'b0, desc_advance, desc_retry, chan_run}, 32'h1);

        // R7: abort held through clear re-aborts
        abort_req = 1'b1;
        step();
        check("R7 abort set", {27'b0, reg_rd_data[31:27]}, 32'h02);
        wr(32'h1000_001F);
        check("R7 clear advances", {28'b0, reg_rd_data[28], desc_advance, desc_retry, chan_run},
              32'h5);
        step();
        check("R7 re-abort", {28'b0, reg_rd_data[28], desc_advance, desc_retry, chan_run},
              32'h8);
        abort_req = 1'b0;
        wr(32'h1000_001F);
        check("R7 final advance", {30'b0, desc_advance, chan_run}, 32'h3);
        step();
        check("R7 idle", {30'b0, desc_advance, chan_run}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule